// File: doc/BRIEF.md
# Byte-Stream Register Command Decoder for a Four-Channel Codec

This block sits behind a serial control port, after the bit shifter. It receives whole bytes, each marked by a one-cycle strobe, inside a frame held open by an active-low chip-select level. It executes register commands against one global register file and four per-channel local register files. The first byte of a command selects read or write, a target space and a 5-bit address. Write commands then take their data bytes from the stream. Read commands produce an outgoing byte stream of one byte per cycle: an identification byte, then the register contents.

Local accesses do not name a channel. A global channel-enable register holds a mask that selects the channels. A local command always moves a pair of adjacent registers, the higher-numbered register first. Coefficient-memory commands are not executed here. They are passed to a separate memory engine as a one-cycle request that carries the direction, the block address and the current channel mask. Raising chip-select abandons any command in flight. Bytes that have already been written stay in place.

Top module: `codec_cmd_decoder`

## Requirements
- R1: A command byte is decoded as bit 7 = direction (1 write, 0 read), bits [6:5] = target (00 local, 01 global, 11 coefficient memory, 10 reserved and ignored: no write, no transmit, busy stays low), and bits [4:0] = address.
- R2: A global write at address 0..7 stores the single data byte that follows in that global register. A global read at the same address returns that byte.
- R3: Global address 5 is the channel-enable register. Bit c of it (c = 0..3) enables channel c for local and coefficient accesses.
- R4: A local command at address a (1..7) moves two data bytes. The first byte goes to local register a and the second to register a-1, so address 1 moves register 1 and then register 0.
- R5: A read starts transmitting in the cycle after its command byte is accepted. It sends one byte per cycle: 8'h81 first, then the data (one byte for global, two for local). Busy is high from the cycle after a local or global command byte until the command completes.
- R6: A local write updates every enabled channel. A local read returns the lowest-numbered enabled channel. With no channel enabled, a write changes nothing and a read returns 8'h00 data.
- R7: Chip-select high aborts the command in progress within that cycle. Transmit stops, busy is low from the next cycle, and data bytes already accepted stay written. Bytes strobed while chip-select is high are ignored.
- R8: Unimplemented addresses (global 8..31, local 0 and 8..31) consume the same number of data bytes as implemented ones. A write to them changes no register. A read from them returns 8'h00 data after the identification byte.
- R9: A coefficient-memory command raises ram_start for exactly one cycle, the cycle after acceptance. It carries ram_write = bit 7, ram_block = bits [4:0] and ram_chan = the channel mask. It transmits nothing and leaves the decoder idle.
- R10: After reset all registers read 8'h00, the channel mask is zero, and busy, tx_valid and ram_start are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rx_valid | input | 1 | One-cycle strobe for a received byte |
| rx_byte | input | 8 | Received byte |
| cs_n | input | 1 | Chip-select level, low while a frame is open |
| tx_valid | output | 1 | Outgoing byte present this cycle |
| tx_byte | output | 8 | Outgoing byte |
| busy | output | 1 | A local or global command is in progress |
| ram_start | output | 1 | One-cycle coefficient-memory request |
| ram_write | output | 1 | Direction of the request, 1 = write |
| ram_block | output | 5 | Block address of the request |
| ram_chan | output | 4 | Channel mask sent with the request |

## Verification
The collision that matters is a chip-select rise that lands in the same cycle as a data byte or an outgoing byte. The abort and the byte transfer then compete for that cycle. The bench provokes this twice. It raises chip-select between the two data bytes of a local write and strobes a byte while the select is still high. It also raises chip-select right after the identification byte of a read. The result is judged at the ports: transmit goes quiet at once and busy drops on the next cycle. A later read returns the new first register next to the untouched second register.

// File: rtl/ccd_pkg.sv
package ccd_pkg;

  localparam int BYTE_W = 8;
  localparam int ADDR_W = 5;

  typedef enum logic [1:0] {
    TGT_LOCAL  = 2'b00,
    TGT_GLOBAL = 2'b01,
    TGT_RSVD   = 2'b10,
    TGT_COEF   = 2'b11
  } tgt_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WDATA = 2'd1,
    ST_READ  = 2'd2
  } pst_e;

  typedef struct packed {
    logic              wr;
    tgt_e              tgt;
    logic [ADDR_W-1:0] addr;
  } cmd_t;

  function automatic cmd_t ccd_decode(input logic [BYTE_W-1:0] b);
    cmd_t c;
    c.wr   = b[7];
    c.tgt  = tgt_e'(b[6:5]);
    c.addr = b[4:0];
    return c;
  endfunction

endpackage

// File: rtl/ccd_parser.sv
module ccd_parser
  import ccd_pkg::*;
#(
  parameter int          NUM_GREG = 8,
  parameter int          NUM_LREG = 8,
  parameter logic [7:0]  ID_CODE  = 8'h81
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              cs_n,
  output logic              g_wr_en,
  output logic              l_wr_en,
  output logic [ADDR_W-1:0] reg_idx,
  output logic [BYTE_W-1:0] wr_data,
  input  logic [BYTE_W-1:0] g_rd_data,
  input  logic [BYTE_W-1:0] l_rd_data,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_byte,
  output logic              busy,
  output logic              ram_start,
  output logic              ram_write,
  output logic [ADDR_W-1:0] ram_block
);

  pst_e              state_q, state_d;
  cmd_t              cmd_q, cmd_d;
  logic [1:0]        cnt_q, cnt_d;
  logic              ok_q, ok_d;
  logic              ram_start_q, ram_start_d;
  logic              ram_write_q, ram_write_d;
  logic [ADDR_W-1:0] ram_block_q, ram_block_d;

  cmd_t       cmd_in;
  logic [1:0] n_data;
  logic [1:0] last_pos;
  logic [1:0] data_pos;

  function automatic logic addr_ok(input tgt_e t, input logic [ADDR_W-1:0] a);
    logic r;
    r = 1'b0;
    if (t == TGT_GLOBAL) r = (32'(a) < NUM_GREG);
    if (t == TGT_LOCAL)  r = (a != '0) && (32'(a) < NUM_LREG);
    return r;
  endfunction

  assign cmd_in   = ccd_decode(rx_byte);
  assign n_data   = (cmd_q.tgt == TGT_LOCAL) ? 2'd2 : 2'd1;
  assign last_pos = n_data - 2'd1;
  assign data_pos = (state_q == ST_READ) ? (cnt_q - 2'd1) : cnt_q;
  assign reg_idx  = cmd_q.addr - {{(ADDR_W-2){1'b0}}, data_pos};
  assign wr_data  = rx_byte;

  // next-state process
  always_comb begin
    state_d     = state_q;
    cmd_d       = cmd_q;
    cnt_d       = cnt_q;
    ok_d        = ok_q;
    ram_start_d = 1'b0;
    ram_write_d = ram_write_q;
    ram_block_d = ram_block_q;
    g_wr_en     = 1'b0;
    l_wr_en     = 1'b0;
    if (cs_n) begin
      state_d = ST_IDLE;
      cnt_d   = '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (rx_valid) begin
            cmd_d = cmd_in;
            cnt_d = '0;
            ok_d  = addr_ok(cmd_in.tgt, cmd_in.addr);
            case (cmd_in.tgt)
              TGT_LOCAL, TGT_GLOBAL: state_d = cmd_in.wr ? ST_WDATA : ST_READ;
              TGT_COEF: begin
                ram_start_d = 1'b1;
                ram_write_d = cmd_in.wr;
                ram_block_d = cmd_in.addr;
              end
              default: ;
            endcase
          end
        end
        ST_WDATA: begin
          if (rx_valid) begin
            g_wr_en = ok_q && (cmd_q.tgt == TGT_GLOBAL);
            l_wr_en = ok_q && (cmd_q.tgt == TGT_LOCAL);
            if (cnt_q == last_pos) begin
              state_d = ST_IDLE;
              cnt_d   = '0;
            end else begin
              cnt_d = cnt_q + 2'd1;
            end
          end
        end
        ST_READ: begin
          if (cnt_q == n_data) begin
            state_d = ST_IDLE;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + 2'd1;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      cmd_q       <= '0;
      cnt_q       <= '0;
      ok_q        <= 1'b0;
      ram_start_q <= 1'b0;
      ram_write_q <= 1'b0;
      ram_block_q <= '0;
    end else begin
      state_q     <= state_d;
      cmd_q       <= cmd_d;
      cnt_q       <= cnt_d;
      ok_q        <= ok_d;
      ram_start_q <= ram_start_d;
      ram_write_q <= ram_write_d;
      ram_block_q <= ram_block_d;
    end
  end

  // outgoing stream
  always_comb begin
    tx_valid = (state_q == ST_READ) && !cs_n;
    tx_byte  = '0;
    if (tx_valid) begin
      if (cnt_q == 2'd0)               tx_byte = ID_CODE;
      else if (!ok_q)                  tx_byte = '0;
      else if (cmd_q.tgt == TGT_LOCAL) tx_byte = l_rd_data;
      else                             tx_byte = g_rd_data;
    end
  end

  assign busy      = (state_q != ST_IDLE);
  assign ram_start = ram_start_q;
  assign ram_write = ram_write_q;
  assign ram_block = ram_block_q;

  AST_ABORT_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> !busy); // R7

  AST_ID_LEADS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && rx_valid && !cs_n && !rx_byte[7] && !rx_byte[6])
    |=> (cs_n || (tx_valid && tx_byte == ID_CODE))); // R5

  AST_RAM_REQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ram_start |-> (!busy && !tx_valid)); // R9

  AST_RAM_REQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    ram_start |-> ($past(rx_valid) && !$past(cs_n) && $past(rx_byte[6:5]) == 2'b11)); // R9

  AST_NO_WRITE_WHILE_TX: assert property (@(posedge clk) disable iff (!rst_n)
    !((g_wr_en || l_wr_en) && tx_valid)); // R5

endmodule

// File: rtl/ccd_global_regs.sv
module ccd_global_regs
  import ccd_pkg::*;
#(
  parameter int NUM_GREG  = 8,
  parameter int NUM_CH    = 4,
  parameter int CHEN_ADDR = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] idx,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [BYTE_W-1:0] rd_data,
  output logic [NUM_CH-1:0] chan_en
);

  localparam int FLAT_W = NUM_GREG * BYTE_W;

  logic [FLAT_W-1:0] flat;

  for (genvar g = 0; g < NUM_GREG; g++) begin : g_reg
    logic              we;
    logic [BYTE_W-1:0] q;
    assign we = wr_en && (idx == ADDR_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (we) q <= wr_data;
    end
    assign flat[g*BYTE_W +: BYTE_W] = q;
  end

  always_comb begin
    rd_data = '0;
    for (int g = 0; g < NUM_GREG; g++) begin
      if (idx == ADDR_W'(g)) rd_data = flat[g*BYTE_W +: BYTE_W];
    end
  end

  assign chan_en = flat[CHEN_ADDR*BYTE_W +: NUM_CH];

  AST_CHEN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && idx == ADDR_W'(CHEN_ADDR)) |=> chan_en == $past(wr_data[NUM_CH-1:0])); // R3

  AST_CHEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(chan_en)); // R3

endmodule

// File: rtl/ccd_local_regs.sv
module ccd_local_regs
  import ccd_pkg::*;
#(
  parameter int NUM_CH   = 4,
  parameter int NUM_LREG = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [NUM_CH-1:0] chan_en,
  input  logic [ADDR_W-1:0] idx,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [BYTE_W-1:0] rd_data
);

  localparam int CH_BITS = NUM_LREG * BYTE_W;

  logic [NUM_CH*CH_BITS-1:0] flat;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    for (genvar r = 0; r < NUM_LREG; r++) begin : g_reg
      logic              we;
      logic [BYTE_W-1:0] q;
      assign we = wr_en && chan_en[c] && (idx == ADDR_W'(r));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  q <= '0;
        else if (we) q <= wr_data;
      end
      assign flat[(c*NUM_LREG + r)*BYTE_W +: BYTE_W] = q;
    end

    AST_MASKED_CH_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      !chan_en[c] |=> $stable(flat[c*CH_BITS +: CH_BITS])); // R6
  end

  // lowest enabled channel answers a read
  always_comb begin
    logic found;
    int   sel;
    found   = 1'b0;
    sel     = 0;
    rd_data = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (!found && chan_en[c]) begin
        found = 1'b1;
        sel   = c;
      end
    end
    for (int c = 0; c < NUM_CH; c++) begin
      for (int r = 0; r < NUM_LREG; r++) begin
        if (found && sel == c && idx == ADDR_W'(r))
          rd_data = flat[(c*NUM_LREG + r)*BYTE_W +: BYTE_W];
      end
    end
  end

endmodule

// File: rtl/codec_cmd_decoder.sv
module codec_cmd_decoder
  import ccd_pkg::*;
#(
  parameter int         NUM_CH    = 4,
  parameter int         NUM_GREG  = 8,
  parameter int         NUM_LREG  = 8,
  parameter int         CHEN_ADDR = 5,
  parameter logic [7:0] ID_CODE   = 8'h81
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [7:0]        rx_byte,
  input  logic              cs_n,
  output logic              tx_valid,
  output logic [7:0]        tx_byte,
  output logic              busy,
  output logic              ram_start,
  output logic              ram_write,
  output logic [4:0]        ram_block,
  output logic [NUM_CH-1:0] ram_chan
);

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic              g_wr_en, l_wr_en;
  logic [ADDR_W-1:0] reg_idx;
  logic [BYTE_W-1:0] wr_data, g_rd_data, l_rd_data;
  logic [NUM_CH-1:0] chan_en;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  ccd_parser #(
    .NUM_GREG (NUM_GREG),
    .NUM_LREG (NUM_LREG),
    .ID_CODE  (ID_CODE)
  ) u_parser (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .rx_valid  (rx_valid),
    .rx_byte   (rx_byte),
    .cs_n      (cs_n),
    .g_wr_en   (g_wr_en),
    .l_wr_en   (l_wr_en),
    .reg_idx   (reg_idx),
    .wr_data   (wr_data),
    .g_rd_data (g_rd_data),
    .l_rd_data (l_rd_data),
    .tx_valid  (tx_valid),
    .tx_byte   (tx_byte),
    .busy      (busy),
    .ram_start (ram_start),
    .ram_write (ram_write),
    .ram_block (ram_block)
  );

  ccd_global_regs #(
    .NUM_GREG  (NUM_GREG),
    .NUM_CH    (NUM_CH),
    .CHEN_ADDR (CHEN_ADDR)
  ) u_gregs (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .wr_en   (g_wr_en),
    .idx     (reg_idx),
    .wr_data (wr_data),
    .rd_data (g_rd_data),
    .chan_en (chan_en)
  );

  ccd_local_regs #(
    .NUM_CH   (NUM_CH),
    .NUM_LREG (NUM_LREG)
  ) u_lregs (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .wr_en   (l_wr_en),
    .chan_en (chan_en),
    .idx     (reg_idx),
    .wr_data (wr_data),
    .rd_data (l_rd_data)
  );

  assign ram_chan = chan_en;

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_int_n |-> (!busy && !tx_valid && !ram_start)); // R10

endmodule

// File: tb/codec_cmd_decoder_test.sv
module codec_cmd_decoder_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_byte = 8'h00;
  logic       cs_n = 1'b0;
  logic       tx_valid, busy, ram_start, ram_write;
  logic [7:0] tx_byte;
  logic [4:0] ram_block;
  logic [3:0] ram_chan;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 0;

  logic [7:0] gm [8];
  logic [7:0] lm [4][8];

  always #5 clk = ~clk;

  codec_cmd_decoder uut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte), .cs_n(cs_n),
    .tx_valid(tx_valid), .tx_byte(tx_byte), .busy(busy), .ram_start(ram_start),
    .ram_write(ram_write), .ram_block(ram_block), .ram_chan(ram_chan)
  );

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    rx_byte  = b;
    rx_valid = 1'b1;
    @(posedge clk); #1;
    rx_valid = 1'b0;
  endtask

  task automatic gwrite(input int a, input logic [7:0] v);
    send(8'hA0 | 8'(a));
    send(v);
    if (a < 8) gm[a] = v;
  endtask

  task automatic lwrite(input int a, input logic [3:0] mask, input logic [7:0] v1, input logic [7:0] v2);
    send(8'h80 | 8'(a));
    send(v1);
    send(v2);
    if (a >= 1 && a < 8) begin
      for (int c = 0; c < 4; c++) begin
        if (mask[c]) begin
          lm[c][a]   = v1;
          lm[c][a-1] = v2;
        end
      end
    end
  endtask

  task automatic rd(input string tag, input logic [7:0] cmd, input int n, input logic [7:0] e0, input logic [7:0] e1);
    send(cmd);
    chk({tag, " id"}, {7'b0, tx_valid, tx_byte}, {8'h01, 8'h81});
    for (int k = 0; k < n; k++) begin
      @(posedge clk); #1;
      chk({tag, " data"}, {7'b0, tx_valid, tx_byte}, {8'h01, (k == 0) ? e0 : e1});
    end
    @(posedge clk); #1;
    chk({tag, " end"}, {14'b0, busy, tx_valid}, 16'h0000);
  endtask

  function automatic logic [7:0] lowest(input logic [3:0] mask, input int r);
    for (int c = 0; c < 4; c++) if (mask[c]) return lm[c][r];
    return 8'h00;
  endfunction

  task automatic report;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000 && !done) begin
        checks++; fails++;
        $display("FAIL watchdog expired");
        report();
      end
    end
  end

  initial begin
    for (int g = 0; g < 8; g++) gm[g] = 8'h00;
    for (int c = 0; c < 4; c++) for (int r = 0; r < 8; r++) lm[c][r] = 8'h00;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    chk("R10 idle outputs", {13'b0, busy, tx_valid, ram_start}, 16'h0000);
    for (int g = 0; g < 8; g++) rd("R10 global reset", 8'h20 | 8'(g), 1, 8'h00, 8'h00);
    rd("R10 local reset", 8'h01, 2, 8'h00, 8'h00);

    // R2 R8: global sweep over every address
    for (int a = 0; a < 32; a++) gwrite(a, 8'(a * 37 + 11));
    for (int a = 0; a < 32; a++) begin
      if (a < 8) rd("R2 global readback", 8'h20 | 8'(a), 1, gm[a], 8'h00);
      else       rd("R8 global unimpl", 8'h20 | 8'(a), 1, 8'h00, 8'h00);
    end

    // R5: busy while waiting for a data byte
    send(8'hA1);
    chk("R5 busy in write", {15'b0, busy}, 16'h0001);
    send(8'h3C); gm[1] = 8'h3C;
    chk("R5 idle after write", {15'b0, busy}, 16'h0000);

    // R3 R4 R6 R8: every mask against every local address class
    for (int m = 0; m < 16; m++) begin
      for (int a = 0; a < 10; a++) begin
        int aa;
        aa = (a == 9) ? 31 : a;
        gwrite(5, 8'(m));
        lwrite(aa, 4'(m), 8'(m * 16 + aa * 3 + 1), 8'(m * 16 + aa * 5 + 2));
        if (aa >= 1 && aa < 8)
          rd("R4 R6 local pair", 8'(aa), 2, lowest(4'(m), aa), lowest(4'(m), aa - 1));
        else
          rd("R8 local unimpl", 8'(aa), 2, 8'h00, 8'h00);
      end
    end
    for (int c = 0; c < 4; c++) begin
      gwrite(5, 8'(1 << c));
      for (int a = 1; a < 8; a += 2)
        rd("R3 R6 per channel", 8'(a), 2, lm[c][a], lm[c][a-1]);
    end

    // R7: abort between the two data bytes of a local write
    gwrite(5, 8'h01);
    lwrite(3, 4'h1, 8'h11, 8'h22);
    send(8'h83);
    send(8'h5A); lm[0][3] = 8'h5A;
    cs_n = 1'b1;
    @(posedge clk); #1;
    chk("R7 abort idle", {15'b0, busy}, 16'h0000);
    send(8'h83);
    chk("R7 ignored while deselected", {15'b0, busy}, 16'h0000);
    cs_n = 1'b0;
    rd("R7 committed byte kept", 8'h03, 2, 8'h5A, 8'h22);

    // R7: abort during a read
    send(8'h03);
    chk("R7 read id", {7'b0, tx_valid, tx_byte}, {8'h01, 8'h81});
    cs_n = 1'b1;
    #1;
    chk("R7 tx stops", {15'b0, tx_valid}, 16'h0000);
    @(posedge clk); #1;
    chk("R7 read aborted", {14'b0, busy, tx_valid}, 16'h0000);
    cs_n = 1'b0;
    @(posedge clk); #1;

    // R9: coefficient-memory hand-off
    gwrite(5, 8'h0A);
    send(8'hE2);
    chk("R9 write request", {5'b0, ram_start, ram_write, ram_block, ram_chan}, {5'b0, 1'b1, 1'b1, 5'd2, 4'hA});
    chk("R9 no tx", {14'b0, busy, tx_valid}, 16'h0000);
    @(posedge clk); #1;
    chk("R9 one cycle", {15'b0, ram_start}, 16'h0000);
    send(8'h69);
    chk("R9 read request", {5'b0, ram_start, ram_write, ram_block, ram_chan}, {5'b0, 1'b1, 1'b0, 5'd9, 4'hA});

    // R1: reserved target does nothing
    send(8'hC4);
    chk("R1 reserved write", {13'b0, busy, tx_valid, ram_start}, 16'h0000);
    send(8'h44);
    chk("R1 reserved read", {13'b0, busy, tx_valid, ram_start}, 16'h0000);
    rd("R1 globals intact", 8'h24, 1, gm[4], 8'h00);

    done = 1;
    report();
  end

endmodule